// File: doc/BRIEF.md
# Receive-to-Transmit Loopback Switch

This block chooses what a serial link transmitter sends in each 10-bit symbol slot. In normal operation it forwards the already encoded transmit symbols. When the link partner asks for loopback, it retransmits the raw 10-bit symbols taken from the receiver instead. These symbols go out bit for bit, with no decoding, re-encoding, scrambling or disparity repair, so even symbols that have no legal 8b/10b meaning are sent back unchanged.

Received symbols arrive with their own strobe and do not line up with transmit slots. A four-entry FIFO holds them until a slot takes them. If a slot finds the FIFO empty, a skip symbol is sent in its place. The source is only changed at a slot boundary. Loopback can only start in the full-power state with the transmitter active. Command combinations that the link rules forbid put the transmitter in electrical idle and set a sticky error flag. A registered copy of every received symbol always goes on to the parallel receive side, whatever the mode.

Top module: `lpbk_switch`

## Requirements
- R1: While `rst` is high, the next clock edge sets `ser_sym` to 0, `elec_idle` to 1, `lpbk_active` to 0, `cmd_err` to 0 and `rx_par_vld` to 0.
- R2: Power state 2'b00 (full power) with `tx_idle` low and `lpbk_req` low is normal mode. At each edge where `tx_slot` is high, `ser_sym` takes `tx_sym` and `elec_idle` goes to 0.
- R3: `ser_sym`, `elec_idle` and `lpbk_active` change only at edges where `tx_slot` is high.
- R4: Loopback mode is state 2'b00, `tx_idle` low and `lpbk_req` high. In this mode every `rx_sym` with `rx_vld` high is queued. Each slot sends the oldest queued symbol exactly as received, including invalid codes such as 10'h000 and 10'h3FF, and sets `lpbk_active` to 1.
- R5: A loopback slot that finds the queue empty sends the skip code 10'b0011110100 (10'h0F4).
- R6: In every mode, `rx_par_sym` and `rx_par_vld` equal `rx_sym` and `rx_vld` one clock later.
- R7: At the first slot after `lpbk_req` goes low in normal conditions, `ser_sym` carries `tx_sym` and `lpbk_active` is 0. Leaving loopback empties the queue, so a later re-entry starts with a skip code.
- R8: `tx_idle` high, or any power state other than 2'b00, makes each slot send 0 with `elec_idle` at 1.
- R9: Two combinations are illegal: state 2'b00 with both `tx_idle` and `lpbk_req` high, and state 2'b01 (standby) with `lpbk_req` high. Either one forces idle and sets `cmd_err`, which stays at 1 until reset. `lpbk_req` in state 2'b10, or in state 2'b11 (handled as 2'b10), is legal and does not set `cmd_err`.
- R10: When the queue already holds four symbols and no slot takes one, a further received symbol is dropped. The four oldest symbols are kept and sent in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_sym | input | 10 | Encoded transmit symbol |
| tx_slot | input | 1 | Transmit symbol slot boundary strobe |
| rx_sym | input | 10 | Raw received symbol |
| rx_vld | input | 1 | Received symbol strobe |
| lpbk_req | input | 1 | Loopback request |
| tx_idle | input | 1 | Transmit electrical-idle request |
| pwr_state | input | 2 | Power state: 00 full, 01 standby, 10 low, 11 treated as 10 |
| ser_sym | output | 10 | Symbol sent to the serializer |
| elec_idle | output | 1 | Transmitter electrical idle |
| lpbk_active | output | 1 | Current slot carries looped-back data |
| rx_par_sym | output | 10 | Received symbol forwarded to the parallel side |
| rx_par_vld | output | 1 | Strobe for `rx_par_sym` |
| cmd_err | output | 1 | Sticky illegal-command flag |

## Verification
Errors in the queue pointers or the count show up at the first loopback slot after the fault. A symbol comes out in the wrong order, is repeated, or turns into a skip code too early or too late. Sending invalid codes and skip-like bit patterns shows whether any recoding happens. A wrong source decision shows up one slot after a command change, as tx data leaking into loopback or loopback data lingering after exit. A sticky flag that clears too soon shows up in the next normal-mode check before reset.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;

    typedef enum logic [1:0] {
        PWR_FULL  = 2'b00,
        PWR_STBY  = 2'b01,
        PWR_LOW   = 2'b10,
        PWR_RSVD  = 2'b11
    } pwr_e;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'b00,
        SRC_TX   = 2'b01,
        SRC_LOOP = 2'b10
    } src_e;

    typedef struct packed {
        src_e src;
        logic illegal;
    } slot_cmd_t;

    localparam logic [9:0] SKIP_CODE = 10'b0011110100;

    function automatic logic cmd_illegal(pwr_e p, logic idle, logic req);
        return ((p == PWR_FULL) && idle && req) || ((p == PWR_STBY) && req);
    endfunction

    function automatic slot_cmd_t decode_cmd(pwr_e p, logic idle, logic req);
        slot_cmd_t c;
        c.illegal = cmd_illegal(p, idle, req);
        if (c.illegal || p != PWR_FULL || idle)
            c.src = SRC_IDLE;
        else if (req)
            c.src = SRC_LOOP;
        else
            c.src = SRC_TX;
        return c;
    endfunction

endpackage

// File: rtl/lpbk_cmd_dec.sv
module lpbk_cmd_dec
    import lpbk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pwr_state,
    input  logic       tx_idle,
    input  logic       lpbk_req,
    output slot_cmd_t  cmd,
    output logic       err_sticky
);

    always_comb begin
        cmd = decode_cmd(pwr_e'(pwr_state), tx_idle, lpbk_req);
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_sticky <= 1'b0;
        else if (cmd.illegal)
            err_sticky <= 1'b1;
    end

endmodule

// File: rtl/lpbk_sym_fifo.sv
module lpbk_sym_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          do_pop, do_push;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && ((cnt != CW'(DEPTH)) || do_pop);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_push && !do_pop)
                cnt <= cnt + 1'b1;
            else if (do_pop && !do_push)
                cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/lpbk_out_stage.sv
module lpbk_out_stage
    import lpbk_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tx_slot,
    input  src_e         src,
    input  logic [W-1:0] tx_sym,
    input  logic [W-1:0] loop_sym,
    input  logic         loop_empty,
    output logic [W-1:0] ser_sym,
    output logic         elec_idle,
    output logic         lpbk_active
);

    localparam logic [W-1:0] SKIP = W'(SKIP_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_sym     <= '0;
            elec_idle   <= 1'b1;
            lpbk_active <= 1'b0;
        end else if (tx_slot) begin
            unique case (src)
                SRC_TX: begin
                    ser_sym     <= tx_sym;
                    elec_idle   <= 1'b0;
                    lpbk_active <= 1'b0;
                end
                SRC_LOOP: begin
                    ser_sym     <= loop_empty ? SKIP : loop_sym;
                    elec_idle   <= 1'b0;
                    lpbk_active <= 1'b1;
                end
                default: begin
                    ser_sym     <= '0;
                    elec_idle   <= 1'b1;
                    lpbk_active <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/lpbk_switch.sv
module lpbk_switch
    import lpbk_pkg::*;
#(
    parameter int SYM_W      = 10,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SYM_W-1:0] tx_sym,
    input  logic             tx_slot,
    input  logic [SYM_W-1:0] rx_sym,
    input  logic             rx_vld,
    input  logic             lpbk_req,
    input  logic             tx_idle,
    input  logic [1:0]       pwr_state,
    output logic [SYM_W-1:0] ser_sym,
    output logic             elec_idle,
    output logic             lpbk_active,
    output logic [SYM_W-1:0] rx_par_sym,
    output logic             rx_par_vld,
    output logic             cmd_err
);

    slot_cmd_t        cmd;
    logic             looping;
    logic [SYM_W-1:0] head;
    logic             q_empty;

    lpbk_cmd_dec u_dec (
        .clk        (clk),
        .rst        (rst),
        .pwr_state  (pwr_state),
        .tx_idle    (tx_idle),
        .lpbk_req   (lpbk_req),
        .cmd        (cmd),
        .err_sticky (cmd_err)
    );

    assign looping = (cmd.src == SRC_LOOP);

    lpbk_sym_fifo #(.W(SYM_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (!looping),
        .push  (rx_vld && looping),
        .din   (rx_sym),
        .pop   (tx_slot && looping),
        .dout  (head),
        .empty (q_empty)
    );

    lpbk_out_stage #(.W(SYM_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .tx_slot     (tx_slot),
        .src         (cmd.src),
        .tx_sym      (tx_sym),
        .loop_sym    (head),
        .loop_empty  (q_empty),
        .ser_sym     (ser_sym),
        .elec_idle   (elec_idle),
        .lpbk_active (lpbk_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_par_sym <= '0;
            rx_par_vld <= 1'b0;
        end else begin
            rx_par_sym <= rx_sym;
            rx_par_vld <= rx_vld;
        end
    end

endmodule

// File: rtl/lpbk_switch_chk.sv
module lpbk_switch_chk #(
    parameter int SYM_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [SYM_W-1:0] tx_sym,
    input logic             tx_slot,
    input logic [SYM_W-1:0] rx_sym,
    input logic             rx_vld,
    input logic             lpbk_req,
    input logic             tx_idle,
    input logic [1:0]       pwr_state,
    input logic [SYM_W-1:0] ser_sym,
    input logic             elec_idle,
    input logic             lpbk_active,
    input logic [SYM_W-1:0] rx_par_sym,
    input logic             rx_par_vld,
    input logic             cmd_err
);

    logic bad_cmd;
    assign bad_cmd = ((pwr_state == 2'b00) && tx_idle && lpbk_req) ||
                     ((pwr_state == 2'b01) && lpbk_req);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (elec_idle && !cmd_err && !lpbk_active && !rx_par_vld));

    assert_slot_only_change_R3: assert property (@(posedge clk) disable iff (rst)
        !tx_slot |=> ($stable(ser_sym) && $stable(elec_idle) && $stable(lpbk_active)));

    assert_loop_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_slot && lpbk_req && !tx_idle && pwr_state == 2'b00) |=> (lpbk_active && !elec_idle));

    assert_rx_forward_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rx_par_vld == $past(rx_vld) && rx_par_sym == $past(rx_sym)));

    assert_exit_immediate_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_slot && !lpbk_req && !tx_idle && pwr_state == 2'b00) |=> (ser_sym == $past(tx_sym) && !lpbk_active));

    assert_idle_forced_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_slot && (tx_idle || pwr_state != 2'b00)) |=> (elec_idle && ser_sym == '0));

    assert_err_set_R9: assert property (@(posedge clk) disable iff (rst)
        bad_cmd |=> cmd_err);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> cmd_err);

endmodule

bind lpbk_switch lpbk_switch_chk #(.SYM_W(SYM_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_sym      (tx_sym),
    .tx_slot     (tx_slot),
    .rx_sym      (rx_sym),
    .rx_vld      (rx_vld),
    .lpbk_req    (lpbk_req),
    .tx_idle     (tx_idle),
    .pwr_state   (pwr_state),
    .ser_sym     (ser_sym),
    .elec_idle   (elec_idle),
    .lpbk_active (lpbk_active),
    .rx_par_sym  (rx_par_sym),
    .rx_par_vld  (rx_par_vld),
    .cmd_err     (cmd_err)
);

// File: tb/tb_lpbk_switch.sv
`timescale 1ns/1ps
module tb_lpbk_switch;

    localparam logic [9:0] SKIP = 10'h0F4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] tx_sym = '0;
    logic       tx_slot = 1'b0;
    logic [9:0] rx_sym = '0;
    logic       rx_vld = 1'b0;
    logic       lpbk_req = 1'b0;
    logic       tx_idle = 1'b1;
    logic [1:0] pwr_state = 2'b10;
    logic [9:0] ser_sym;
    logic       elec_idle;
    logic       lpbk_active;
    logic [9:0] rx_par_sym;
    logic       rx_par_vld;
    logic       cmd_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lpbk_switch dut (
        .clk(clk), .rst(rst), .tx_sym(tx_sym), .tx_slot(tx_slot),
        .rx_sym(rx_sym), .rx_vld(rx_vld), .lpbk_req(lpbk_req),
        .tx_idle(tx_idle), .pwr_state(pwr_state), .ser_sym(ser_sym),
        .elec_idle(elec_idle), .lpbk_active(lpbk_active),
        .rx_par_sym(rx_par_sym), .rx_par_vld(rx_par_vld), .cmd_err(cmd_err)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cmd(input logic [1:0] p, input logic idle, input logic req);
        pwr_state = p;
        tx_idle   = idle;
        lpbk_req  = req;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        chk("R1 ser_sym", ser_sym, 0);
        chk("R1 elec_idle", elec_idle, 1);
        chk("R1 lpbk_active", lpbk_active, 0);
        chk("R1 cmd_err", cmd_err, 0);
        chk("R1 rx_par_vld", rx_par_vld, 0);
        rst = 1'b0;
    endtask

    task automatic t_normal();
        logic [9:0] vals [3] = '{10'h17C, 10'h2A5, 10'h0F0};
        set_cmd(2'b00, 1'b0, 1'b0);
        tx_slot = 1'b1;
        foreach (vals[i]) begin
            tx_sym = vals[i];
            step();
            chk("R2 ser_sym", ser_sym, vals[i]);
            chk("R2 elec_idle", elec_idle, 0);
        end
    endtask

    task automatic t_slot_gate();
        tx_slot = 1'b0;
        tx_sym  = 10'h155;
        step();
        chk("R3 hold between slots", ser_sym, 10'h0F0);
        step();
        chk("R3 hold second cycle", ser_sym, 10'h0F0);
        tx_slot = 1'b1;
        step();
        chk("R3 update at slot", ser_sym, 10'h155);
    endtask

    task automatic t_rx_pass();
        rx_sym = 10'h3C3;
        rx_vld = 1'b1;
        step();
        chk("R6 rx_par_sym", rx_par_sym, 10'h3C3);
        chk("R6 rx_par_vld", rx_par_vld, 1);
        rx_vld = 1'b0;
        step();
        chk("R6 rx_par_vld low", rx_par_vld, 0);
    endtask

    task automatic t_loop();
        logic [9:0] syms [3] = '{10'h000, 10'h3FF, 10'h2AA};
        tx_slot = 1'b0;
        set_cmd(2'b00, 1'b0, 1'b1);
        foreach (syms[i]) begin
            rx_sym = syms[i];
            rx_vld = 1'b1;
            step();
            chk("R6 forwarded during loopback", rx_par_sym, syms[i]);
        end
        rx_vld  = 1'b0;
        tx_slot = 1'b1;
        tx_sym  = 10'h1E1;
        foreach (syms[i]) begin
            step();
            chk("R4 looped symbol", ser_sym, syms[i]);
            chk("R4 lpbk_active", lpbk_active, 1);
        end
        step();
        chk("R5 skip on empty", ser_sym, SKIP);
    endtask

    task automatic t_exit();
        tx_slot = 1'b0;
        rx_vld  = 1'b1;
        rx_sym  = 10'h111;
        step();
        rx_sym  = 10'h222;
        step();
        rx_vld  = 1'b0;
        lpbk_req = 1'b0;
        tx_slot  = 1'b1;
        tx_sym   = 10'h0AB;
        step();
        chk("R7 tx data resumes", ser_sym, 10'h0AB);
        chk("R7 lpbk_active low", lpbk_active, 0);
        lpbk_req = 1'b1;
        step();
        chk("R7 queue flushed on exit", ser_sym, SKIP);
        lpbk_req = 1'b0;
        step();
    endtask

    task automatic t_overflow();
        tx_slot = 1'b0;
        lpbk_req = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            rx_sym = 10'h100 + 10'(i);
            rx_vld = 1'b1;
            step();
        end
        rx_vld  = 1'b0;
        tx_slot = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            step();
            chk("R10 oldest kept", ser_sym, 10'h100 + 10'(i));
        end
        step();
        chk("R10 extras dropped", ser_sym, SKIP);
        lpbk_req = 1'b0;
        step();
    endtask

    task automatic t_idle();
        tx_slot = 1'b1;
        tx_sym  = 10'h1FF;
        set_cmd(2'b00, 1'b1, 1'b0);
        step();
        chk("R8 idle flag", elec_idle, 1);
        chk("R8 idle symbol", ser_sym, 0);
        chk("R8 no error", cmd_err, 0);
        set_cmd(2'b10, 1'b1, 1'b1);
        step();
        chk("R9 low-power request legal", cmd_err, 0);
        chk("R8 low-power idle", elec_idle, 1);
        set_cmd(2'b11, 1'b1, 1'b1);
        step();
        chk("R9 state 11 as low power", cmd_err, 0);
        chk("R8 state 11 idle", elec_idle, 1);
    endtask

    task automatic t_illegal();
        tx_slot = 1'b1;
        set_cmd(2'b00, 1'b1, 1'b1);
        step();
        chk("R9 full-power combo idle", elec_idle, 1);
        chk("R9 full-power combo err", cmd_err, 1);
        set_cmd(2'b00, 1'b0, 1'b0);
        tx_sym = 10'h0CC;
        step();
        chk("R9 err sticky", cmd_err, 1);
        chk("R2 normal after illegal", ser_sym, 10'h0CC);
        do_reset();
        set_cmd(2'b01, 1'b0, 1'b1);
        step();
        chk("R9 standby request err", cmd_err, 1);
        chk("R9 standby request idle", elec_idle, 1);
        set_cmd(2'b10, 1'b1, 1'b0);
        do_reset();
    endtask

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_normal();
        t_slot_gate();
        t_rx_pass();
        t_loop();
        t_exit();
        t_overflow();
        t_idle();
        t_illegal();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule